// File: doc/BRIEF.md
# Clock-Select Register Bank with Staged Commit

This block is a word-addressed register bank holding clock-configuration entries. Software changes one bit field of an entry without a read-modify-write. Each entry has three word addresses. One reads back its current content. One ORs the write data into the entry. One clears every bit that is 1 in the write data. Changing a 4-bit source field therefore takes two writes: clear the field with 0xF at its shift, then set the new code if the code is nonzero.

Entry content is only pending. Two entries drive clock-source selects: tap A (entry 22, bits 3:0) and tap B (entry 28, bits 19:16). The live select of a tap moves only when a 1 is written to that tap's assigned bit of an update word. The update bit is a self-clearing strobe. The live select takes the entry's field on the next clock edge.

The word map is as follows. Word 0 is a mode word with no effect. Words 1 to 4 are update words. Words 5 to 7 are reserved. Entry k occupies words 8+3k (current), 9+3k (set) and 10+3k (clear). For tap A, source code 8 selects the PLL and code 0 selects the 26 MHz reference. For tap B, code 7 selects the PLL and code 0 selects the reference.

Top module: `csel_bank`

## Requirements
- R1: After reset every entry reads 0, and both live selects (sel_a_o, sel_b_o) are 0, which selects the 26 MHz reference.
- R2: A write to word 9+3k ORs the write data into entry k. Word 8+3k then reads the updated entry in the same cycle as the address is presented.
- R3: A write to word 10+3k clears the bits of entry k where the write data is 1 and leaves the other bits unchanged.
- R4: A change to an entry's pending content does not change either live select until the matching update strobe is written.
- R5: Writing a word to update word 2 (address 3) with bit 24 set loads bits 3:0 of entry 22 into sel_a_o on the following clock edge.
- R6: Writing a word to update word 3 (address 4) with bit 18 set loads bits 19:16 of entry 28 into sel_b_o on the following clock edge.
- R7: Update writes without a tap's assigned bit, or to another update word, leave that tap's live select unchanged.
- R8: The mode word, update words, reserved words and the set and clear addresses all read 0. Writes to mode, reserved words or update words change no entry.
- R9: The full switch sequence works in both directions. Forward: tap A to 8 and tap B to 7, each committed through its update bit. Back: both taps to 0. Each select ends at the written code.
- R10: Addresses at or above 95 (past the last entry) read 0, and writes to them change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write enable for the addressed word |
| addr_i | input | 7 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| sel_a_o | output | 4 | Live select of tap A (entry 22, bits 3:0) |
| sel_b_o | output | 4 | Live select of tap B (entry 28, bits 19:16) |

## Verification
The bench builds the bank with its default parameters: 29 entries, four update words, three reserved words and a 7-bit word address. With these values both taps sit at entries 22 and 28, at field shifts 0 and 16. The last entry ends at word 94, so addresses 95 to 127 exist in the address space and can be driven as out-of-range writes and reads. The shifted tap B field and the update bits that belong to no tap are exercised under these same values.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_MODE,
    OP_UPD,
    OP_RSV,
    OP_CUR,
    OP_SET,
    OP_CLR
  } csel_op_e;
endpackage

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned N_ENTRY   = 29,
  parameter int unsigned UPD_REGS  = 4,
  parameter int unsigned RSV_WORDS = 3,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned UIDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csel_op_e          op_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [UIDX_W-1:0] uidx_o
);
  localparam int unsigned UPD_BASE   = 1;
  localparam int unsigned RSV_BASE   = UPD_BASE + UPD_REGS;
  localparam int unsigned ENTRY_BASE = RSV_BASE + RSV_WORDS;
  localparam int unsigned ENTRY_END  = ENTRY_BASE + 3 * N_ENTRY;

  int unsigned a, off, sub;

  always_comb begin
    a      = 32'(addr_i);
    off    = a - ENTRY_BASE;
    sub    = off % 3;
    idx_o  = IDX_W'(off / 3);
    uidx_o = UIDX_W'(a - UPD_BASE);
    op_o   = OP_NONE;
    if (a == 0)                                   op_o = OP_MODE;
    else if (a < RSV_BASE)                        op_o = OP_UPD;
    else if (a < ENTRY_BASE)                      op_o = OP_RSV;
    else if (a < ENTRY_END) begin
      // triple order within an entry is cur, set, clr
      case (sub)
        0:       op_o = OP_CUR;
        1:       op_o = OP_SET;
        default: op_o = OP_CLR;
      endcase
    end
  end
endmodule

// File: rtl/csel_entry.sv
module csel_entry #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= '0;
    else if (clr_i) val_o <= val_o & ~wdata_i;
    else if (set_i) val_o <= val_o | wdata_i;
  end
endmodule

// File: rtl/csel_tap.sv
module csel_tap #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [SEL_W-1:0] pend_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_o <= '0;
    else if (stb_i) sel_o <= pend_i;
  end
endmodule

// File: rtl/csel_bank.sv
module csel_bank
  import csel_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned N_ENTRY   = 29,
  parameter int unsigned UPD_REGS  = 4,
  parameter int unsigned RSV_WORDS = 3,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned A_ENTRY   = 22,
  parameter int unsigned A_SHIFT   = 0,
  parameter int unsigned A_UREG    = 2,
  parameter int unsigned A_UBIT    = 24,
  parameter int unsigned B_ENTRY   = 28,
  parameter int unsigned B_SHIFT   = 16,
  parameter int unsigned B_UREG    = 3,
  parameter int unsigned B_UBIT    = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  sel_a_o,
  output logic [SEL_W-1:0]  sel_b_o
);
  localparam int unsigned IDX_W  = $clog2(N_ENTRY);
  localparam int unsigned UIDX_W = (UPD_REGS > 1) ? $clog2(UPD_REGS) : 1;

  csel_op_e          op;
  logic [IDX_W-1:0]  idx;
  logic [UIDX_W-1:0] uidx;
  logic [DATA_W-1:0] val [N_ENTRY];
  logic [SEL_W-1:0]  pend_a, pend_b;
  logic              stb_a, stb_b;

  csel_decode #(
    .ADDR_W(ADDR_W), .N_ENTRY(N_ENTRY), .UPD_REGS(UPD_REGS),
    .RSV_WORDS(RSV_WORDS), .IDX_W(IDX_W), .UIDX_W(UIDX_W)
  ) i_decode (
    .addr_i(addr_i), .op_o(op), .idx_o(idx), .uidx_o(uidx)
  );

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_entry
    logic hit;
    assign hit = we_i && (idx == IDX_W'(i));
    csel_entry #(.DATA_W(DATA_W)) i_entry (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(hit && op == OP_SET),
      .clr_i(hit && op == OP_CLR),
      .wdata_i(wdata_i),
      .val_o(val[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (op == OP_CUR && 32'(idx) < N_ENTRY) rdata_o = val[idx];
  end

  assign pend_a = val[A_ENTRY][A_SHIFT +: SEL_W];
  assign pend_b = val[B_ENTRY][B_SHIFT +: SEL_W];
  assign stb_a  = we_i && op == OP_UPD && uidx == UIDX_W'(A_UREG) && wdata_i[A_UBIT];
  assign stb_b  = we_i && op == OP_UPD && uidx == UIDX_W'(B_UREG) && wdata_i[B_UBIT];

  csel_tap #(.SEL_W(SEL_W)) i_tap_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb_a), .pend_i(pend_a), .sel_o(sel_a_o)
  );
  csel_tap #(.SEL_W(SEL_W)) i_tap_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb_b), .pend_i(pend_b), .sel_o(sel_b_o)
  );
endmodule

// File: rtl/csel_bank_chk.sv
module csel_bank_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned SEL_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [SEL_W-1:0]  sel_a_o,
  input logic [SEL_W-1:0]  sel_b_o,
  input logic [SEL_W-1:0]  pend_a,
  input logic [SEL_W-1:0]  pend_b
);
  logic upd_a, upd_b;
  assign upd_a = we_i && addr_i == ADDR_W'(3) && wdata_i[24];
  assign upd_b = we_i && addr_i == ADDR_W'(4) && wdata_i[18];

  a_r4_hold_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_a |=> $stable(sel_a_o));
  a_r7_hold_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_b |=> $stable(sel_b_o));
  a_r5_commit_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_a |=> sel_a_o == $past(pend_a));
  a_r6_commit_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_b |=> sel_b_o == $past(pend_b));
  a_r8_upd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= ADDR_W'(1) && addr_i <= ADDR_W'(7)) |-> rdata_o == '0);
  a_r10_oor_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= ADDR_W'(95)) |-> rdata_o == '0);
endmodule

bind csel_bank csel_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) i_chk (.*);

// File: tb/test_csel_bank.sv
module test_csel_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  sel_a_o, sel_b_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  csel_bank i_csel_bank (.*);

  always #4 clk_i = ~clk_i;

  function automatic int cur_a(int k);  return 8 + 3 * k;  endfunction
  function automatic int set_a(int k);  return 9 + 3 * k;  endfunction
  function automatic int clr_a(int k);  return 10 + 3 * k; endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 7'(a); wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr_i = 7'(a);
    #1;
    d = rdata_o;
  endtask

  task automatic setfield(int k, int sh, logic [3:0] v);
    wr(clr_a(k), 32'hF << sh);
    if (v != 0) wr(set_a(k), 32'(v) << sh);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(cur_a(22), d); chk("R1 entry22", d, 0);
    rd(cur_a(28), d); chk("R1 entry28", d, 0);
    chk("R1 sel_a", 32'(sel_a_o), 0);
    chk("R1 sel_b", 32'(sel_b_o), 0);
  endtask

  task automatic t_set_clr;
    logic [31:0] d;
    wr(set_a(5), 32'h0000_00A5);
    rd(cur_a(5), d); chk("R2 set", d, 32'h0000_00A5);
    wr(set_a(5), 32'h0F00_0F00);
    rd(cur_a(5), d); chk("R2 or", d, 32'h0F00_0FA5);
    wr(clr_a(5), 32'h0F00_0005);
    rd(cur_a(5), d); chk("R3 clr", d, 32'h0000_0FA0);
    rd(cur_a(4), d); chk("R3 neighbour", d, 0);
  endtask

  task automatic t_tap_a;
    logic [31:0] d;
    setfield(22, 0, 4'd8);
    rd(cur_a(22), d); chk("R4 pending a", d, 32'h8);
    chk("R4 sel_a held", 32'(sel_a_o), 0);
    wr(3, 32'h0100_0000);
    chk("R5 sel_a commit", 32'(sel_a_o), 8);
    chk("R7 sel_b untouched", 32'(sel_b_o), 0);
  endtask

  task automatic t_tap_b;
    logic [31:0] d;
    setfield(28, 16, 4'd7);
    rd(cur_a(28), d); chk("R4 pending b", d, 32'h0007_0000);
    wr(4, ~32'h0004_0000);
    chk("R7 wrong bit", 32'(sel_b_o), 0);
    wr(3, 32'h0004_0000);
    chk("R7 wrong word", 32'(sel_b_o), 0);
    wr(4, 32'h0004_0000);
    chk("R6 sel_b commit", 32'(sel_b_o), 7);
    chk("R9 forward a", 32'(sel_a_o), 8);
  endtask

  task automatic t_side;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      if (a != 3 && a != 4) wr(a, 32'hFFFF_FFFF);
    end
    for (int a = 0; a < 8; a++) begin
      rd(a, d); chk("R8 ctrl read", d, 0);
    end
    rd(set_a(22), d); chk("R8 set read", d, 0);
    rd(clr_a(28), d); chk("R8 clr read", d, 0);
    rd(cur_a(0), d);  chk("R8 entry0 kept", d, 0);
    rd(cur_a(22), d); chk("R8 entry22 kept", d, 32'h8);
    chk("R8 sel_a kept", 32'(sel_a_o), 8);
    chk("R8 sel_b kept", 32'(sel_b_o), 7);
  endtask

  task automatic t_range;
    logic [31:0] d;
    for (int a = 95; a < 128; a++) wr(a, 32'hFFFF_FFFF);
    for (int a = 95; a < 128; a++) begin
      rd(a, d); chk("R10 oor read", d, 0);
    end
    rd(cur_a(0), d);  chk("R10 entry0 kept", d, 0);
    rd(cur_a(28), d); chk("R10 entry28 kept", d, 32'h0007_0000);
  endtask

  task automatic t_back;
    setfield(28, 16, 4'd0);
    wr(4, 32'h0004_0000);
    chk("R9 back b", 32'(sel_b_o), 0);
    chk("R9 a still pll", 32'(sel_a_o), 8);
    setfield(22, 0, 4'd0);
    wr(3, 32'h0100_0000);
    chk("R9 back a", 32'(sel_a_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_set_clr();
    t_tap_a();
    t_tap_b();
    t_side();
    t_range();
    t_back();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule